// File: doc/BRIEF.md
# Luma and chroma offset adjuster

This stage sits in a standard-definition YCbCr pixel path. Each clock it may accept one sample of 8-bit luma plus 8-bit Cb and Cr, marked by a valid strobe. It shifts the luma by a brightness offset and each chroma channel by its own offset, then clamps every result to the unsigned sample range. Samples leave in arrival order, two clock cycles after they enter. The valid strobe travels through the pipeline alongside the data.

Three 8-bit settings control the shifts, and they are loaded through a one-cycle write port. The brightness setting is a two's-complement code: 0x00 leaves luma unchanged, 0x7F adds the most and 0x80 subtracts the most. The two chroma settings use offset binary centred on 0x80. When a sample is accepted, all three settings are captured with it. Every sample is therefore processed with one consistent set of settings, even when a write lands in the same cycle.

Top module: `yc_offset_adj`

## Requirements
- R1: A sample accepted with `in_valid` high at a clock edge appears on the outputs with `out_valid` high exactly two clock edges later. Samples keep their order, and `out_valid` is low in every cycle that carries no sample.
- R2: During and right after reset `out_valid` is low. Reset sets brightness to 0x00 and both chroma settings to 0x80, so samples pass through unchanged until the first write.
- R3: A write with `cfg_sel` = 1 sets the Cb code. The Cb output is the Cb input plus (code − 128), and the code has no effect on the luma or Cr outputs.
- R4: A write with `cfg_sel` = 2 sets the Cr code. The Cr output is the Cr input plus (code − 128), and the code has no effect on the luma or Cb outputs.
- R5: A write with `cfg_sel` = 0 sets the brightness code b, read as a signed 8-bit value. Luma gains floor(b × 60 / 128) steps. Code 0x7F adds 59, 0x80 subtracts 60, 0x40 adds 30, 0xFF subtracts 1 and 0x01 adds 0.
- R6: Each sum is formed at signed width. A sum below 0 is output as 0, and a sum above 255 is output as 255.
- R7: A write that lands in the same cycle as an accepted sample does not affect that sample. It applies to samples accepted at later edges.
- R8: A write with `cfg_sel` = 3 changes none of the three settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_sel | input | 2 | Setting select: 0 brightness, 1 Cb, 2 Cr, 3 none |
| cfg_wdata | input | CW (8) | Code to write |
| in_valid | input | 1 | Input sample strobe |
| in_y | input | DW (8) | Input luma |
| in_cb | input | DW (8) | Input Cb |
| in_cr | input | DW (8) | Input Cr |
| out_valid | output | 1 | Output sample strobe |
| out_y | output | DW (8) | Adjusted luma |
| out_cb | output | DW (8) | Adjusted Cb |
| out_cr | output | DW (8) | Adjusted Cr |

## Verification
The bench builds the block with its default parameters: 8-bit samples and codes, a 10-bit sum, and a luma scale of 60/128. With these values the extreme codes 0x00, 0x7F, 0x80 and 0xFF yield offsets large enough to push samples near 0 or 255 through both clamps. The floor rounding of the luma scale shows at small negative codes, where 0xFF gives −1 and not 0. Running samples back to back with a write in the same cycle puts the settings snapshot of R7 directly at the ports.

// File: rtl/yc_adj_pkg.sv
package yc_adj_pkg;
   typedef enum logic [1:0] {
      SEL_BRIGHT = 2'd0,
      SEL_CB     = 2'd1,
      SEL_CR     = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   localparam int unsigned NCHAN   = 3;
   localparam int unsigned CH_LUMA = 0;
   localparam int unsigned CH_CB   = 1;
   localparam int unsigned CH_CR   = 2;
endpackage

// File: rtl/yc_cfg_regs.sv
module yc_cfg_regs #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] bri_code,
   output logic [CW-1:0] cb_code,
   output logic [CW-1:0] cr_code
);
   import yc_adj_pkg::*;

   localparam logic [CW-1:0] MID_CODE = CW'(1) << (CW - 1);

   cfg_sel_e sel_e;
   assign sel_e = cfg_sel_e'(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bri_code <= '0;
         cb_code  <= MID_CODE;
         cr_code  <= MID_CODE;
      end else if (we) begin
         case (sel_e)
            SEL_BRIGHT: bri_code <= wdata;
            SEL_CB:     cb_code  <= wdata;
            SEL_CR:     cr_code  <= wdata;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/yc_offset_map.sv
module yc_offset_map #(
   parameter int unsigned CW            = 8,
   parameter int unsigned OW            = 10,
   parameter bit          OFFSET_BINARY = 1'b0,
   parameter int unsigned MUL           = 60,
   parameter int unsigned SHIFT         = 7
) (
   input  logic [CW-1:0]        code,
   output logic signed [OW-1:0] ofs
);
   localparam int unsigned PW = CW + $clog2(MUL + 1) + 1;

   if (OW <= CW) begin : g_bad_ow
      $error("yc_offset_map: OW must exceed CW");
   end

   if (OFFSET_BINARY) begin : g_obin
      localparam logic [OW-1:0] MID = OW'(1) << (CW - 1);
      logic [OW-1:0] ext;
      assign ext = {{(OW - CW){1'b0}}, code};
      assign ofs = $signed(ext - MID);
   end else begin : g_scaled
      if (PW < OW) begin : g_bad_pw
         $error("yc_offset_map: product narrower than offset");
      end
      logic signed [PW-1:0] code_s;
      logic signed [PW-1:0] prod;
      logic signed [PW-1:0] shifted;
      assign code_s  = PW'($signed(code));
      assign prod    = code_s * $signed(PW'(MUL));
      assign shifted = prod >>> SHIFT;
      assign ofs     = shifted[OW-1:0];
   end
endmodule

// File: rtl/yc_sat_add.sv
module yc_sat_add #(
   parameter int unsigned DW = 8,
   parameter int unsigned OW = 10
) (
   input  logic [DW-1:0]        smp,
   input  logic signed [OW-1:0] ofs,
   output logic [DW-1:0]        res
);
   localparam logic signed [OW-1:0] TOP = $signed(OW'((1 << DW) - 1));

   if (OW < DW + 2) begin : g_bad_ow
      $error("yc_sat_add: OW must be at least DW+2");
   end

   logic signed [OW-1:0] sum;
   assign sum = $signed({{(OW - DW){1'b0}}, smp}) + ofs;

   always_comb begin
      if (sum < 0)        res = '0;
      else if (sum > TOP) res = '1;
      else                res = sum[DW-1:0];
   end
endmodule

// File: rtl/yc_offset_adj.sv
module yc_offset_adj #(
   parameter int unsigned DW         = 8,
   parameter int unsigned CW         = 8,
   parameter int unsigned SUM_W      = 10,
   parameter int unsigned LUMA_MUL   = 60,
   parameter int unsigned LUMA_SHIFT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [CW-1:0] cfg_wdata,
   input  logic          in_valid,
   input  logic [DW-1:0] in_y,
   input  logic [DW-1:0] in_cb,
   input  logic [DW-1:0] in_cr,
   output logic          out_valid,
   output logic [DW-1:0] out_y,
   output logic [DW-1:0] out_cb,
   output logic [DW-1:0] out_cr
);
   import yc_adj_pkg::*;

   if (SUM_W < DW + 2 || SUM_W <= CW) begin : g_bad_sum
      $error("yc_offset_adj: SUM_W too narrow");
   end

   logic [CW-1:0] bri_code, cb_code, cr_code;

   yc_cfg_regs #(.CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .bri_code(bri_code),
      .cb_code(cb_code), .cr_code(cr_code)
   );

   logic [DW-1:0]           smp_in [NCHAN];
   logic [CW-1:0]           code   [NCHAN];
   logic signed [SUM_W-1:0] ofs_c  [NCHAN];
   logic [DW-1:0]           s1_smp [NCHAN];
   logic signed [SUM_W-1:0] s1_ofs [NCHAN];
   logic [DW-1:0]           res    [NCHAN];
   logic [DW-1:0]           s2_res [NCHAN];
   logic                    s1_valid;

   assign smp_in[CH_LUMA] = in_y;
   assign smp_in[CH_CB]   = in_cb;
   assign smp_in[CH_CR]   = in_cr;
   assign code[CH_LUMA]   = bri_code;
   assign code[CH_CB]     = cb_code;
   assign code[CH_CR]     = cr_code;

   for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
      yc_offset_map #(
         .CW(CW), .OW(SUM_W),
         .OFFSET_BINARY(ch != CH_LUMA),
         .MUL(LUMA_MUL), .SHIFT(LUMA_SHIFT)
      ) u_map (
         .code(code[ch]), .ofs(ofs_c[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_smp[ch] <= '0;
            s1_ofs[ch] <= '0;
         end else if (in_valid) begin
            s1_smp[ch] <= smp_in[ch];
            s1_ofs[ch] <= ofs_c[ch];
         end
      end

      yc_sat_add #(.DW(DW), .OW(SUM_W)) u_add (
         .smp(s1_smp[ch]), .ofs(s1_ofs[ch]), .res(res[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        s2_res[ch] <= '0;
         else if (s1_valid) s2_res[ch] <= res[ch];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_valid  <= in_valid;
         out_valid <= s1_valid;
      end
   end

   assign out_y  = s2_res[CH_LUMA];
   assign out_cb = s2_res[CH_CB];
   assign out_cr = s2_res[CH_CR];
endmodule

// File: rtl/yc_offset_adj_chk.sv
module yc_offset_adj_chk #(
   parameter int unsigned DW = 8,
   parameter int unsigned CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [1:0]    cfg_sel,
   input logic [CW-1:0] cfg_wdata,
   input logic          in_valid,
   input logic [DW-1:0] in_y,
   input logic [DW-1:0] in_cb,
   input logic [DW-1:0] in_cr,
   input logic          out_valid,
   input logic [DW-1:0] out_y,
   input logic [DW-1:0] out_cb,
   input logic [DW-1:0] out_cr
);
   localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);

   logic [CW-1:0] trk_cb, trk_cr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_cb <= MID;
         trk_cr <= MID;
      end else if (cfg_we) begin
         if (cfg_sel == 2'd1) trk_cb <= cfg_wdata;
         if (cfg_sel == 2'd2) trk_cr <= cfg_wdata;
      end
   end

   // R1: output strobe follows the input strobe by two edges
   p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R2: first edge after reset carries no sample
   p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !out_valid);

   // R3: neutral Cb code leaves Cb untouched
   p_cb_neutral_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(trk_cb, 2) == MID) |-> out_cb == $past(in_cb, 2));

   // R4: neutral Cr code leaves Cr untouched
   p_cr_neutral_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(trk_cr, 2) == MID) |-> out_cr == $past(in_cr, 2));

   // R5: luma moves by no more than -60..+59 steps
   p_luma_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((int'(out_y) + 60 >= int'($past(in_y, 2))) &&
                     (int'(out_y) <= int'($past(in_y, 2)) + 59)));
endmodule

bind yc_offset_adj yc_offset_adj_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_yc_offset_adj.sv
module sim_yc_offset_adj;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [7:0] cfg_wdata = 8'd0;
   logic       in_valid = 1'b0;
   logic [7:0] in_y = 8'd0, in_cb = 8'd0, in_cr = 8'd0;
   logic       out_valid;
   logic [7:0] out_y, out_cb, out_cr;

   always #10 clk = ~clk;

   yc_offset_adj u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_y(in_y),
      .in_cb(in_cb), .in_cr(in_cr), .out_valid(out_valid),
      .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
   );

   typedef struct {
      logic [7:0] y, cb, cr;
      int         cyc;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0, errs = 0, cyc = 0;
   logic [7:0] m_bri = 8'h00, m_cb = 8'h80, m_cr = 8'h80;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string msg);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s", req, msg);
      end
   endtask

   function automatic logic [7:0] clamp(input int v);
      if (v < 0)   return 8'd0;
      if (v > 255) return 8'd255;
      return v[7:0];
   endfunction

   function automatic int luma_ofs(input logic [7:0] c);
      int s;
      s = int'($signed(c));
      return (s * 60) >>> 7;
   endfunction

   // one cycle: optional write and optional sample, driven at the falling edge
   task automatic step(input bit we, input logic [1:0] sel, input logic [7:0] wd,
                       input bit v, input logic [7:0] y, input logic [7:0] cb,
                       input logic [7:0] cr, input string req);
      exp_t e;
      @(negedge clk);
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      in_valid = v; in_y = y; in_cb = cb; in_cr = cr;
      if (v) begin
         e.y   = clamp(int'(y) + luma_ofs(m_bri));
         e.cb  = clamp(int'(cb) + int'(m_cb) - 128);
         e.cr  = clamp(int'(cr) + int'(m_cr) - 128);
         e.cyc = cyc + 2;
         e.req = req;
         exp_q.push_back(e);
      end
      if (we) begin
         case (sel)
            2'd0: m_bri = wd;
            2'd1: m_cb  = wd;
            2'd2: m_cr  = wd;
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] wd);
      step(1'b1, sel, wd, 1'b0, 8'd0, 8'd0, 8'd0, "");
   endtask

   task automatic px(input logic [7:0] y, input logic [7:0] cb,
                     input logic [7:0] cr, input string req);
      step(1'b0, 2'd0, 8'd0, 1'b1, y, cb, cr, req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'd0, 1'b0, 8'd0, 8'd0, 8'd0, "");
   endtask

   // monitor: pops the scoreboard when the design produces a sample
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected out_valid, expected none");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cyc == e.cyc, "R1",
                $sformatf("latency: actual cyc %0d expected %0d", cyc, e.cyc));
            chk({out_y, out_cb, out_cr} == {e.y, e.cb, e.cr}, e.req,
                $sformatf("actual y/cb/cr %0d/%0d/%0d expected %0d/%0d/%0d",
                          out_y, out_cb, out_cr, e.y, e.cb, e.cr));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R2", $sformatf("in reset out_valid actual %0b expected 0", out_valid));
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", $sformatf("after reset out_valid actual %0b expected 0", out_valid));

      // R2: defaults pass video through
      px(8'd16, 8'd128, 8'd128, "R2");
      px(8'd235, 8'd16, 8'd240, "R2");
      px(8'd0, 8'd255, 8'd0, "R2");
      idle(1);
      px(8'd255, 8'd1, 8'd254, "R1");
      idle(2);
      px(8'd77, 8'd88, 8'd99, "R1");

      // R3: Cb offset only
      wr(2'd1, 8'h90);
      px(8'd100, 8'd100, 8'd100, "R3");
      wr(2'd1, 8'h70);
      px(8'd100, 8'd100, 8'd100, "R3");
      wr(2'd1, 8'h80);

      // R4: Cr offset only
      wr(2'd2, 8'h70);
      px(8'd50, 8'd60, 8'd70, "R4");
      wr(2'd2, 8'hA5);
      px(8'd50, 8'd60, 8'd70, "R4");
      wr(2'd2, 8'h80);

      // R5: brightness scaling and rounding
      wr(2'd0, 8'h7F); px(8'd100, 8'd128, 8'd128, "R5");
      wr(2'd0, 8'h80); px(8'd100, 8'd128, 8'd128, "R5");
      wr(2'd0, 8'h40); px(8'd100, 8'd128, 8'd128, "R5");
      wr(2'd0, 8'hFF); px(8'd100, 8'd128, 8'd128, "R5");
      wr(2'd0, 8'h01); px(8'd100, 8'd128, 8'd128, "R5");

      // R6: clamping at both ends
      wr(2'd0, 8'h7F); px(8'd250, 8'd128, 8'd128, "R6");
      wr(2'd0, 8'h80); px(8'd20, 8'd128, 8'd128, "R6");
      wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
      px(8'd60, 8'd200, 8'd50, "R6");
      px(8'd61, 8'd128, 8'd127, "R6");

      // R7: write and sample in the same cycle, then back-to-back samples
      wr(2'd0, 8'h00); wr(2'd1, 8'h80); wr(2'd2, 8'h80);
      step(1'b1, 2'd0, 8'h7F, 1'b1, 8'd100, 8'd100, 8'd100, "R7");
      px(8'd100, 8'd100, 8'd100, "R7");
      step(1'b1, 2'd1, 8'h00, 1'b1, 8'd10, 8'd150, 8'd30, "R7");
      px(8'd10, 8'd150, 8'd30, "R7");

      // R8: select 3 changes nothing
      wr(2'd0, 8'h00); wr(2'd1, 8'h80);
      wr(2'd3, 8'h00);
      px(8'd123, 8'd45, 8'd67, "R8");
      wr(2'd3, 8'hFF);
      px(8'd9, 8'd250, 8'd3, "R8");

      idle(4);
      chk(exp_q.size() == 0, "R1",
          $sformatf("pending samples actual %0d expected 0", exp_q.size()));
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule